// File: doc/BRIEF.md
# Peak-Current PWM Slope Compensator

This block times one switching period of a synchronous step-down power stage run under peak current mode control. A free-running period counter splits the system clock into fixed switching periods. At the start of each period a compensation ramp is loaded with the controller command scaled by sixteen, then falls by a programmable step on every clock, stopping at zero. The ramp value drives the comparator reference DAC outside the block. The digitized result of that comparator comes back as a trip bit, and the trip ends the high-side conduction for the rest of the period.

The gate sequencer is a five-state machine. IDLE holds both gates off after reset. At every period boundary it enters LEAD_GAP (both gates off for the dead time). When the dead time has run out it moves to HIGH_ON, or straight to TRAIL_GAP if a trip is already latched or the on-time limit is zero. HIGH_ON moves to TRAIL_GAP on a trip or when the on-time limit is reached. TRAIL_GAP (both gates off for the dead time) moves to LOW_ON, and LOW_ON holds the low side on until the next boundary, which moves every state back to LOW_ON's successor LEAD_GAP. The block also gives a one-clock ADC sample trigger at the falling edge of a reference phase that is high from the period start up to a programmed count.

Command, slope step, dead time, on-time limit and reference phase are taken from shadow inputs only at the period boundary, so software may write them at any time.

Top module: `pcm_slope_pwm`

## Requirements
- R1: A switching period lasts PERIOD clocks (default 450); `period_start` is high for the first clock of each period, and the first period begins on the first clock after reset is released.
- R2: In the first clock of a period `ramp` equals the command that was on `cmd_shadow` in the last clock of the previous period, multiplied by 16.
- R3: In every other clock `ramp` is its previous value minus the latched slope step, or zero when the step is not smaller than the previous value; it never wraps.
- R4: When `trip_in` is high in any clock except the last one of a period, `hs_gate` is low in the following clock and stays low until the next period.
- R5: `hs_gate` and `ls_gate` are never high together, and a gate rises only after a clock in which both were low.
- R6: Each period starts with both gates low for max(dead time,1) clocks; after the high-side on-time ends both gates stay low for max(dead time,1) clocks, then `ls_gate` is high up to the end of the period.
- R7: `adc_trig` is high for exactly one clock per period, in the clock whose period count (0 at the period start) equals the latched reference phase; a reference phase of 0 or of PERIOD or more gives no pulse.
- R8: A trip is held until the next period start, so the trip input falling again does not restart the on-time; a trip seen only in the last clock of a period has no effect on the next period.
- R9: `hs_gate` stays high for at most the latched on-time limit in clocks; a limit of 0 keeps it low for the whole period.
- R10: Dead time, on-time limit, slope step, command and reference phase are sampled only in the last clock of a period; changes at other times have no effect until then.
- R11: While reset is asserted all outputs are low and `ramp` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_shadow | input | CMD_W | Controller peak command, taken at the boundary |
| slope_shadow | input | CMD_W+RAMP_SHIFT | Ramp decrement per clock, taken at the boundary |
| dead_shadow | input | DT_W | Dead time in clocks (0 acts as 1) |
| maxon_shadow | input | clog2(PERIOD) | High-side on-time limit in clocks |
| ref_shadow | input | clog2(PERIOD) | Count at which the reference phase falls |
| trip_in | input | 1 | Digitized current comparator trip |
| hs_gate | output | 1 | High-side switch drive |
| ls_gate | output | 1 | Low-side switch drive |
| ramp | output | CMD_W+RAMP_SHIFT | Compensation ramp to the comparator DAC |
| period_start | output | 1 | First clock of each period |
| adc_trig | output | 1 | Voltage ADC sample trigger pulse |

## Verification
The period boundary and the trip latch can act in the same clock: a trip raised in the last clock of a period meets the boundary reload, and the bench drives exactly that while the on-time limit is longer than the period, judging that the next period still gets its full on-time. The trip and the on-time limit can also end the high side in the same clock; the bench places a trip on the clock in which the limit is reached and expects one TRAIL_GAP entry and no extra high clock. A clock-by-clock model in the bench predicts every output, so both collisions are judged on every signal.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    // Gate sequencer states
    typedef enum logic [2:0] {
        GS_IDLE      = 3'd0,
        GS_LEAD_GAP  = 3'd1,
        GS_HIGH_ON   = 3'd2,
        GS_TRAIL_GAP = 3'd3,
        GS_LOW_ON    = 3'd4
    } gate_state_t;

endpackage

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
    parameter int PERIOD = 450,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ref_in,
    output logic             wrap_o,
    output logic             start_o,
    output logic             adc_trig_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ref_q;

    assign wrap_o = (cnt == LAST);

    // Reset parks the counter on the last count so the first edge opens a period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= LAST;
            ref_q <= '0;
        end else if (wrap_o) begin
            cnt   <= '0;
            ref_q <= ref_in;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign start_o    = (cnt == '0);
    // Reference phase is high for counts below ref_q; its falling edge is at ref_q
    assign adc_trig_o = (ref_q != '0) && (cnt == ref_q);

endmodule

// File: rtl/pcm_ramp_gen.sv
module pcm_ramp_gen #(
    parameter int CMD_W      = 12,
    parameter int RAMP_SHIFT = 4,
    localparam int RAMP_W    = CMD_W + RAMP_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic [RAMP_W-1:0] slope_in,
    output logic [RAMP_W-1:0] ramp_o
);

    logic [RAMP_W-1:0] peak;
    logic [RAMP_W-1:0] slope_q;

    generate
        if (RAMP_SHIFT == 0) begin : g_noscale
            assign peak = cmd_in;
        end else begin : g_scale
            assign peak = {cmd_in, {RAMP_SHIFT{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_o  <= '0;
            slope_q <= '0;
        end else if (wrap) begin
            ramp_o  <= peak;
            slope_q <= slope_in;
        end else if (ramp_o > slope_q) begin
            ramp_o  <= ramp_o - slope_q;
        end else begin
            ramp_o  <= '0;
        end
    end

endmodule

// File: rtl/pcm_gate_fsm.sv
module pcm_gate_fsm
    import pcm_pkg::*;
#(
    parameter int PERIOD = 450,
    parameter int DT_W   = 6,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             trip_in,
    input  logic [DT_W-1:0]  dead_in,
    input  logic [CNT_W-1:0] maxon_in,
    output logic             hs_o,
    output logic             ls_o,
    output logic [CNT_W-1:0] maxon_q
);

    gate_state_t      st, st_n;
    logic [DT_W-1:0]  gap, gap_n;
    logic [CNT_W-1:0] on_cnt, on_n;
    logic [DT_W-1:0]  dead_q;
    logic             trip_lat;
    logic             tripped;
    logic             gap_done;
    logic             on_done;

    assign tripped  = trip_in | trip_lat;
    assign gap_done = ((DT_W+1)'(gap) + 1'b1) >= (DT_W+1)'(dead_q);
    assign on_done  = ((CNT_W+1)'(on_cnt) + 1'b1) >= (CNT_W+1)'(maxon_q);

    // Next-state decision
    always_comb begin
        st_n  = st;
        gap_n = gap;
        on_n  = on_cnt;
        if (wrap) begin
            st_n  = GS_LEAD_GAP;
            gap_n = '0;
            on_n  = '0;
        end else begin
            unique case (st)
                GS_IDLE: begin
                end
                GS_LEAD_GAP: begin
                    if (gap_done) begin
                        st_n  = (tripped || maxon_q == '0) ? GS_TRAIL_GAP : GS_HIGH_ON;
                        gap_n = '0;
                        on_n  = '0;
                    end else begin
                        gap_n = gap + 1'b1;
                    end
                end
                GS_HIGH_ON: begin
                    if (tripped || on_done) begin
                        st_n  = GS_TRAIL_GAP;
                        gap_n = '0;
                    end else begin
                        on_n  = on_cnt + 1'b1;
                    end
                end
                GS_TRAIL_GAP: begin
                    if (gap_done) st_n = GS_LOW_ON;
                    else          gap_n = gap + 1'b1;
                end
                GS_LOW_ON: begin
                end
                default: st_n = GS_IDLE;
            endcase
        end
    end

    // State register and period-latched settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= GS_IDLE;
            gap      <= '0;
            on_cnt   <= '0;
            dead_q   <= '0;
            maxon_q  <= '0;
            trip_lat <= 1'b0;
        end else begin
            st     <= st_n;
            gap    <= gap_n;
            on_cnt <= on_n;
            if (wrap) begin
                dead_q   <= dead_in;
                maxon_q  <= maxon_in;
                trip_lat <= 1'b0;
            end else begin
                trip_lat <= tripped;
            end
        end
    end

    // Output decode
    always_comb begin
        hs_o = 1'b0;
        ls_o = 1'b0;
        unique case (st)
            GS_HIGH_ON: hs_o = 1'b1;
            GS_LOW_ON:  ls_o = 1'b1;
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pcm_slope_pwm.sv
module pcm_slope_pwm #(
    parameter int PERIOD     = 450,
    parameter int CMD_W      = 12,
    parameter int RAMP_SHIFT = 4,
    parameter int DT_W       = 6,
    localparam int CNT_W     = $clog2(PERIOD),
    localparam int RAMP_W    = CMD_W + RAMP_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_shadow,
    input  logic [RAMP_W-1:0] slope_shadow,
    input  logic [DT_W-1:0]   dead_shadow,
    input  logic [CNT_W-1:0]  maxon_shadow,
    input  logic [CNT_W-1:0]  ref_shadow,
    input  logic              trip_in,
    output logic              hs_gate,
    output logic              ls_gate,
    output logic [RAMP_W-1:0] ramp,
    output logic              period_start,
    output logic              adc_trig
);

    logic             wrap;
    logic [CNT_W-1:0] maxon_q;

    pcm_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_shadow),
        .wrap_o     (wrap),
        .start_o    (period_start),
        .adc_trig_o (adc_trig)
    );

    pcm_ramp_gen #(.CMD_W(CMD_W), .RAMP_SHIFT(RAMP_SHIFT)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .cmd_in   (cmd_shadow),
        .slope_in (slope_shadow),
        .ramp_o   (ramp)
    );

    pcm_gate_fsm #(.PERIOD(PERIOD), .DT_W(DT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .trip_in  (trip_in),
        .dead_in  (dead_shadow),
        .maxon_in (maxon_shadow),
        .hs_o     (hs_gate),
        .ls_o     (ls_gate),
        .maxon_q  (maxon_q)
    );

endmodule

// File: rtl/pcm_slope_pwm_chk.sv
module pcm_slope_pwm_chk #(
    parameter int PERIOD     = 450,
    parameter int CMD_W      = 12,
    parameter int RAMP_SHIFT = 4,
    localparam int CNT_W     = $clog2(PERIOD),
    localparam int RAMP_W    = CMD_W + RAMP_SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wrap,
    input logic              period_start,
    input logic              hs_gate,
    input logic              ls_gate,
    input logic [RAMP_W-1:0] ramp,
    input logic [CMD_W-1:0]  cmd_shadow,
    input logic              trip_in,
    input logic [CNT_W-1:0]  maxon_q
);

    logic [CNT_W:0] since_start;
    logic           seen_start;
    logic [CNT_W:0] hs_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_start <= '0;
            seen_start  <= 1'b0;
            hs_run      <= '0;
        end else begin
            if (period_start) begin
                since_start <= '0;
                seen_start  <= 1'b1;
            end else if (since_start != '1) begin
                since_start <= since_start + 1'b1;
            end
            hs_run <= hs_gate ? hs_run + 1'b1 : '0;
        end
    end

    assert_period_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && seen_start) |-> (since_start == (CNT_W+1)'(PERIOD - 1)));

    assert_ramp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (ramp == (RAMP_W'($past(cmd_shadow)) << RAMP_SHIFT)));

    assert_ramp_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> (ramp <= $past(ramp)));

    assert_trip_ends_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_in && !wrap) |=> !hs_gate);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    assert_gap_before_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(ls_gate) == 1'b0));

    assert_gap_before_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(hs_gate) == 1'b0));

    assert_on_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_gate |-> (hs_run < (CNT_W+1)'(maxon_q)));

endmodule

bind pcm_slope_pwm pcm_slope_pwm_chk #(
    .PERIOD     (PERIOD),
    .CMD_W      (CMD_W),
    .RAMP_SHIFT (RAMP_SHIFT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrap         (wrap),
    .period_start (period_start),
    .hs_gate      (hs_gate),
    .ls_gate      (ls_gate),
    .ramp         (ramp),
    .cmd_shadow   (cmd_shadow),
    .trip_in      (trip_in),
    .maxon_q      (maxon_q)
);

// File: tb/sim_pcm_slope_pwm.sv
`timescale 1ns/1ps
module sim_pcm_slope_pwm;

    localparam int P  = 450;
    localparam int CW = 12;
    localparam int SH = 4;
    localparam int DW = 6;
    localparam int NW = $clog2(P);
    localparam int RW = CW + SH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cmd_shadow = '0;
    logic [RW-1:0] slope_shadow = '0;
    logic [DW-1:0] dead_shadow = '0;
    logic [NW-1:0] maxon_shadow = '0;
    logic [NW-1:0] ref_shadow = '0;
    logic          trip_in = 1'b0;
    logic          hs_gate, ls_gate, period_start, adc_trig;
    logic [RW-1:0] ramp;

    int checks = 0;
    int failures = 0;
    int scen = 0;
    int trip_at = 0;

    // Reference model state: 0 idle, 1 lead gap, 2 high, 3 trail gap, 4 low
    int m_cnt = P - 1, m_st = 0, m_gap = 0, m_on = 0, m_tl = 0;
    int m_ramp = 0, m_slope = 0, m_dt = 0, m_mx = 0, m_ref = 0;

    always #4 clk = ~clk;

    pcm_slope_pwm #(.PERIOD(P), .CMD_W(CW), .RAMP_SHIFT(SH), .DT_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_shadow(cmd_shadow), .slope_shadow(slope_shadow),
        .dead_shadow(dead_shadow), .maxon_shadow(maxon_shadow), .ref_shadow(ref_shadow),
        .trip_in(trip_in), .hs_gate(hs_gate), .ls_gate(ls_gate), .ramp(ramp),
        .period_start(period_start), .adc_trig(adc_trig)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = P - 1; m_st = 0; m_gap = 0; m_on = 0; m_tl = 0;
            m_ramp = 0; m_slope = 0; m_dt = 0; m_mx = 0; m_ref = 0;
        end else if (m_cnt == P - 1) begin
            m_cnt = 0; m_st = 1; m_gap = 0; m_on = 0; m_tl = 0;
            m_ramp = int'(cmd_shadow) * 16; m_slope = int'(slope_shadow);
            m_dt = int'(dead_shadow); m_mx = int'(maxon_shadow); m_ref = int'(ref_shadow);
        end else begin
            int eff;
            bit tr;
            tr = trip_in || (m_tl != 0);
            eff = (m_dt < 1) ? 1 : m_dt;
            m_cnt++;
            m_ramp = (m_ramp > m_slope) ? m_ramp - m_slope : 0;
            case (m_st)
                1: if (m_gap + 1 >= eff) begin
                       m_st = (tr || m_mx == 0) ? 3 : 2;
                       m_gap = 0; m_on = 0;
                   end else m_gap++;
                2: if (tr || m_on + 1 >= m_mx) begin
                       m_st = 3; m_gap = 0;
                   end else m_on++;
                3: if (m_gap + 1 >= eff) m_st = 4;
                   else m_gap++;
                default: ;
            endcase
            m_tl = tr ? 1 : 0;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(int'(period_start), (m_cnt == 0) ? 1 : 0, "R1 period_start");
        chk(int'(ramp), m_ramp, "R2 R3 R10 ramp");
        chk(int'(hs_gate), (m_st == 2) ? 1 : 0, "R4 R8 R9 hs_gate");
        chk(int'(ls_gate), (m_st == 4) ? 1 : 0, "R5 R6 ls_gate");
        chk(int'(adc_trig), (m_ref != 0 && m_cnt == m_ref) ? 1 : 0, "R7 adc_trig");
    endtask

    function automatic bit trip_for(int c);
        case (scen)
            1: return c == trip_at;                       // single pulse
            2: return (c >= 100 && c <= 120) && (c % 2 == 0); // chatter, R8
            3: return c == 2;                              // during lead gap
            4: return c == P - 1;                          // on the boundary, R8
            5: return c == trip_at;                        // same clock as on-time limit
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_periods(input int n);
        for (int i = 0; i < n * P; i++) begin
            @(negedge clk);
            compare_all();
            trip_in = trip_for(m_cnt);
        end
    endtask

    task automatic set_cfg(input int c, input int s, input int d, input int mx, input int rf);
        cmd_shadow = CW'(c); slope_shadow = RW'(s); dead_shadow = DW'(d);
        maxon_shadow = NW'(mx); ref_shadow = NW'(rf);
    endtask

    initial begin
        #2_000_000;
        checks++; failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        set_cfg(100, 48, 3, 300, 180);
        repeat (3) @(negedge clk);
        // R11: outputs held low while in reset
        chk(int'(hs_gate), 0, "R11 hs in reset");
        chk(int'(ls_gate), 0, "R11 ls in reset");
        chk(int'(ramp), 0, "R11 ramp in reset");
        chk(int'(period_start), 0, "R11 start in reset");
        chk(int'(adc_trig), 0, "R11 adc in reset");
        rst_n = 1'b1;

        scen = 0; run_periods(2);                          // R9 limit ends on-time
        scen = 1; trip_at = 120; run_periods(2);           // R4
        scen = 2; run_periods(2);                          // R8 chatter
        set_cfg(200, 30, 5, 300, 100);
        scen = 3; run_periods(2);                          // trip in lead gap
        set_cfg(200, 30, 3, 500, 100);
        scen = 4; run_periods(2);                          // boundary trip, R8
        set_cfg(150, 20, 3, 200, 300);
        scen = 5; trip_at = 202; run_periods(2);           // trip meets limit
        scen = 1; trip_at = 300;
        repeat (77) @(negedge clk) begin compare_all(); trip_in = trip_for(m_cnt); end
        set_cfg(4095, 1, 2, 250, 50);                      // R10 mid-period change
        run_periods(2);
        set_cfg(2500, 60000, 4, 250, 449);                 // R3 saturation
        run_periods(2);
        set_cfg(300, 48, 0, 100, 0);                       // R6 zero dead time, R7 no pulse
        scen = 0; run_periods(2);
        set_cfg(300, 48, 63, 0, 460);                      // R9 zero limit, R7 out of range
        run_periods(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule